// File: doc/BRIEF.md
# Byte-Array Write-Protect Gate

This block stands between a byte-write request port and a 256-byte storage array. Each write request carries an address and a data byte. The block either commits the byte to the array or refuses it, and it reports the outcome on a one-cycle pulse. The array is divided into two halves by the top address bit. The low half can be locked by software commands. The high half accepts every write.

The low half has two separate locks. The sticky lock can be engaged by a command, and after that only a power-on reset releases it. The soft lock can be engaged and released by commands any number of times. While the sticky lock is engaged, any command aimed at the soft lock is refused and flagged, and the soft lock keeps its value. Reads are combinational and neither lock affects them.

Top module: `spd_wp_ctrl`

## Requirements
- R1: After reset `prot_status` is 2'b00 and `wr_ok`, `wr_rej` and `cmd_rej` are all 0.
- R2: When both locks are off, a write to the low half (address bit 7 = 0) is stored at the clock edge. `wr_ok` is high for the following cycle, and the new byte can be read from then on.
- R3: A write to the high half (address bit 7 = 1) is always stored and answered with `wr_ok`, whatever the lock state.
- R4: `cmd_set_rev` engages the soft lock and `cmd_clr_rev` releases it. `prot_status[0]` shows the soft lock and `prot_status[1]` shows the sticky lock, each one cycle after the command.
- R5: A write to the low half while either lock is engaged leaves the array unchanged and is answered with a one-cycle `wr_rej` pulse instead of `wr_ok`.
- R6: `cmd_set_perm` engages the sticky lock. No command releases it; only reset does.
- R7: While the sticky lock is engaged, `cmd_set_rev` or `cmd_clr_rev` causes a one-cycle `cmd_rej` pulse and leaves `prot_status[0]` unchanged.
- R8: `rd_data` always shows the stored byte at `rd_addr`, whatever the lock state.
- R9: If `cmd_set_rev` and `cmd_clr_rev` are asserted in the same cycle while the sticky lock is off, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| cmd_set_perm | input | 1 | Engage the sticky lock |
| cmd_set_rev | input | 1 | Engage the soft lock |
| cmd_clr_rev | input | 1 | Release the soft lock |
| wr_ok | output | 1 | Pulse: the last write was stored |
| wr_rej | output | 1 | Pulse: the last write was refused |
| cmd_rej | output | 1 | Pulse: a soft-lock command was refused |
| prot_status | output | 2 | {sticky lock, soft lock} |

## Verification
The bench uses the default parameters, ADDR_W = 8 and DATA_W = 8, so the full 256-byte map is covered. With these values the directed writes can land on the edges of the two halves: 00h, 7Fh, 80h and FFh. The bench steps the locks through off, soft only, both soft commands in one cycle, and sticky. At each step it checks that the low half refuses or accepts writes as required and that the high half and reads are never affected.

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmd_set_perm,
  input  logic              cmd_set_rev,
  input  logic              cmd_clr_rev,
  output logic              wr_ok,
  output logic              wr_rej,
  output logic              cmd_rej,
  output logic [1:0]        prot_status
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic perm_q, rev_q;

  wire low_half = ~wr_addr[ADDR_W-1];
  wire blocked  = low_half & (perm_q | rev_q);
  wire rev_cmd  = cmd_set_rev | cmd_clr_rev;

  always_ff @(posedge clk)
    if (wr_en && !blocked) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q  <= 1'b0;
      rev_q   <= 1'b0;
      wr_ok   <= 1'b0;
      wr_rej  <= 1'b0;
      cmd_rej <= 1'b0;
    end else begin
      wr_ok   <= wr_en & ~blocked;
      wr_rej  <= wr_en & blocked;
      cmd_rej <= perm_q & rev_cmd;
      if (cmd_set_perm) perm_q <= 1'b1;
      if (!perm_q) begin
        if (cmd_set_rev)      rev_q <= 1'b1;
        else if (cmd_clr_rev) rev_q <= 1'b0;
      end
    end
  end

  assign rd_data     = mem[rd_addr];
  assign prot_status = {perm_q, rev_q};
endmodule

// File: rtl/spd_wp_ctrl_chk.sv
module spd_wp_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cmd_set_perm,
  input logic              cmd_set_rev,
  input logic              cmd_clr_rev,
  input logic              wr_ok,
  input logic              wr_rej,
  input logic              cmd_rej,
  input logic [1:0]        prot_status
);
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && wr_rej));

  assert_high_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[ADDR_W-1] |=> wr_ok);

  assert_low_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_addr[ADDR_W-1] && (prot_status != 2'b00) |=> wr_rej);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prot_status[1] |=> prot_status[1]);

  assert_soft_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_status[1] && (cmd_set_rev || cmd_clr_rev) |=> cmd_rej && $stable(prot_status[0]));

  assert_soft_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_status[1] && cmd_set_rev |=> prot_status[0]);

  assert_soft_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_status[1] && cmd_clr_rev && !cmd_set_rev |=> !prot_status[0]);

  assert_perm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set_perm |=> prot_status[1]);
endmodule

bind spd_wp_ctrl spd_wp_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .cmd_set_perm(cmd_set_perm), .cmd_set_rev(cmd_set_rev), .cmd_clr_rev(cmd_clr_rev),
  .wr_ok(wr_ok), .wr_rej(wr_rej), .cmd_rej(cmd_rej), .prot_status(prot_status)
);

// File: tb/spd_wp_ctrl_tb_top.sv
module spd_wp_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic cmd_set_perm = 1'b0, cmd_set_rev = 1'b0, cmd_clr_rev = 1'b0;
  logic wr_ok, wr_rej, cmd_rej;
  logic [1:0] prot_status;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spd_wp_ctrl #(.ADDR_W(8), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmd_set_perm(cmd_set_perm),
    .cmd_set_rev(cmd_set_rev), .cmd_clr_rev(cmd_clr_rev), .wr_ok(wr_ok),
    .wr_rej(wr_rej), .cmd_rej(cmd_rej), .prot_status(prot_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_cmd(input bit sp, input bit sr, input bit cr);
    @(negedge clk);
    cmd_set_perm = sp; cmd_set_rev = sr; cmd_clr_rev = cr;
    @(negedge clk);
    cmd_set_perm = 1'b0; cmd_set_rev = 1'b0; cmd_clr_rev = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    check("R1 status", prot_status, 2'b00);
    check("R1 wr_ok", wr_ok, 0);
    check("R1 wr_rej", wr_rej, 0);
    check("R1 cmd_rej", cmd_rej, 0);
  endtask

  task automatic t_open_low();
    do_write(8'h00, 8'hA5);
    check("R2 wr_ok 00h", wr_ok, 1);
    read_at(8'h00, 8'hA5, "R2 data 00h");
    do_write(8'h7F, 8'h3C);
    check("R2 wr_ok 7Fh", wr_ok, 1);
    read_at(8'h7F, 8'h3C, "R2 data 7Fh");
    do_write(8'h10, 8'h22);
    check("R2 wr_rej low", wr_rej, 0);
  endtask

  task automatic t_soft_lock();
    do_cmd(0, 1, 0);
    check("R4 soft set", prot_status, 2'b01);
    do_write(8'h10, 8'h11);
    check("R5 wr_rej soft", wr_rej, 1);
    check("R5 wr_ok soft", wr_ok, 0);
    read_at(8'h10, 8'h22, "R5 unchanged soft");
    do_write(8'h80, 8'h77);
    check("R3 wr_ok 80h soft", wr_ok, 1);
    read_at(8'h80, 8'h77, "R3 data 80h");
    read_at(8'h00, 8'hA5, "R8 read while soft");
    do_cmd(0, 0, 1);
    check("R4 soft clr", prot_status, 2'b00);
    do_write(8'h10, 8'h44);
    check("R4 wr_ok after clr", wr_ok, 1);
    read_at(8'h10, 8'h44, "R4 data after clr");
  endtask

  task automatic t_both_cmds();
    do_cmd(0, 1, 1);
    check("R9 set wins", prot_status, 2'b01);
    check("R9 no cmd_rej", cmd_rej, 0);
    do_cmd(0, 0, 1);
    check("R9 cleared", prot_status, 2'b00);
  endtask

  task automatic t_sticky();
    do_cmd(1, 0, 0);
    check("R6 sticky set", prot_status, 2'b10);
    do_write(8'h7F, 8'hEE);
    check("R5 wr_rej sticky", wr_rej, 1);
    read_at(8'h7F, 8'h3C, "R5 unchanged sticky");
    do_write(8'hFF, 8'h5A);
    check("R3 wr_ok FFh sticky", wr_ok, 1);
    read_at(8'hFF, 8'h5A, "R3 data FFh");
    do_cmd(0, 1, 0);
    check("R7 cmd_rej set", cmd_rej, 1);
    check("R7 soft unchanged", prot_status, 2'b10);
    do_cmd(0, 0, 1);
    check("R7 cmd_rej clr", cmd_rej, 1);
    check("R6 sticky kept", prot_status, 2'b10);
    @(negedge clk);
    check("R7 pulse ends", cmd_rej, 0);
    read_at(8'h00, 8'hA5, "R8 read while sticky");
  endtask

  task automatic t_reset_release();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R6 reset releases", prot_status, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_open_low();
    t_soft_lock();
    t_both_cmds();
    t_sticky();
    t_reset_release();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule